// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

A purely combinational arithmetic logic unit for a 32-bit integer datapath. Two operands and a 3-bit operation code go in. A result word, a zero flag and a signed overflow flag come out in the same cycle. There is no register or pipeline stage anywhere in the block.

Internally the unit is a chain of identical 1-bit slices. Each slice has a full adder and a 4-way selector that picks among AND, OR, the adder sum and a "less" input. One negate control, which is the top bit of the operation code, inverts every b bit and also puts a carry of one into the lowest slice. The adder therefore produces a - b as a + ~b + 1.

Signed set-on-less-than reuses the subtraction. The most significant slice forms a "set" bit, which is its sum corrected by the overflow flag. That bit is routed back to the less input of bit 0. The less inputs of all other slices are held at 0. An equality test is a subtraction followed by a look at the zero flag.

Top module: `bitslice_alu`

## Requirements
- R1: Code 3'b000 gives the bitwise AND of a and b.
- R2: Code 3'b001 gives the bitwise OR of a and b.
- R3: Code 3'b010 gives a + b modulo 2^32.
- R4: Code 3'b110 gives a - b modulo 2^32.
- R5: Code 3'b111 gives a result whose bit 0 is 1 exactly when a < b as signed two's complement numbers, and whose bits 31..1 are 0. This holds even when a - b overflows.
- R6: zero is 1 exactly when all 32 result bits are 0. With code 3'b110 it is therefore 1 exactly when a equals b.
- R7: With code 3'b010, overflow is 1 exactly when a and b have the same sign bit (bit 31) and the sum's sign bit differs from it. Operands of opposite sign never set it.
- R8: With code 3'b110, overflow is 1 exactly when a and b differ in sign bit and the difference's sign bit differs from a's. Operands of equal sign never set it.
- R9: overflow is 0 for codes 3'b000, 3'b001 and 3'b111, whatever the operands.
- R10: Codes 3'b011, 3'b100 and 3'b101 give an all-zero result and overflow 0, so zero reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| op_i | input | 3 | Operation code; bit 2 is the negate control |
| res_o | output | 32 | Result word |
| zero_o | output | 1 | High when res_o is all zero |
| ovf_o | output | 1 | Signed overflow of add or subtract |

## Verification
The bench runs every operation code over all pairs of 0, 1, -1, the largest positive value and the most negative value. This drives the carry out of the top slice and the sign-flip cases together.

The most negative value minus one catches two faults. A less-than bit taken from the raw sum sign, without the overflow correction, reports the wrong order. A negate path that inverts b but forgets the carry-in is off by one everywhere in subtract and compare.

Same-sign subtracts and opposite-sign adds expose an overflow detector that looks at the operand signs alone. The unused codes and the logic codes expose a design that lets the less path or the overflow flag leak through.

// File: rtl/bitslice_alu.sv
module bitslice_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   op_i,
  output logic [W-1:0] res_o,
  output logic         zero_o,
  output logic         ovf_o
);
  localparam logic [2:0] OP_AND = 3'b000;
  localparam logic [2:0] OP_OR  = 3'b001;
  localparam logic [2:0] OP_ADD = 3'b010;
  localparam logic [2:0] OP_SUB = 3'b110;
  localparam logic [2:0] OP_SLT = 3'b111;

  logic         negate;
  logic [1:0]   sel;
  logic [W-1:0] bx, sum, less, raw;
  logic         carry_top, carry_msb_in, ovf_raw, set_bit, legal;

  assign negate = op_i[2];
  assign sel    = op_i[1:0];
  assign bx     = b_i ^ {W{negate}};

  // ripple of full-adder slices
  always_comb begin
    logic c;
    c = negate;
    carry_msb_in = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (i == W - 1) carry_msb_in = c;
      sum[i] = a_i[i] ^ bx[i] ^ c;
      c      = (a_i[i] & bx[i]) | (a_i[i] & c) | (bx[i] & c);
    end
    carry_top = c;
  end

  assign ovf_raw = carry_top ^ carry_msb_in;
  assign set_bit = sum[W-1] ^ ovf_raw;
  assign less    = {{(W-1){1'b0}}, set_bit};

  // per-slice output selector
  always_comb begin
    for (int i = 0; i < W; i++) begin
      case (sel)
        2'd0:    raw[i] = a_i[i] & b_i[i];
        2'd1:    raw[i] = a_i[i] | b_i[i];
        2'd2:    raw[i] = sum[i];
        default: raw[i] = less[i];
      endcase
    end
  end

  assign legal  = (op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_ADD) ||
                  (op_i == OP_SUB) || (op_i == OP_SLT);
  assign res_o  = legal ? raw : '0;
  assign zero_o = ~|res_o;
  assign ovf_o  = ((op_i == OP_ADD) || (op_i == OP_SUB)) & ovf_raw;

  always_comb begin
    if (op_i == OP_ADD)
      p_add_r3: assert (res_o == W'(a_i + b_i)) else $error("p_add_r3");
    if (op_i == OP_SUB)
      p_sub_r4: assert (res_o == W'(a_i - b_i)) else $error("p_sub_r4");
    if (op_i == OP_SLT)
      p_slt_r5: assert (res_o == {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))})
        else $error("p_slt_r5");
    if (op_i == OP_SUB)
      p_eq_zero_r6: assert (zero_o == (a_i == b_i)) else $error("p_eq_zero_r6");
    if (op_i == OP_ADD && a_i[W-1] != b_i[W-1])
      p_no_overflow_r7: assert (!ovf_o) else $error("p_no_overflow_r7");
    if (op_i == OP_SUB && a_i[W-1] == b_i[W-1])
      p_no_overflow_r8: assert (!ovf_o) else $error("p_no_overflow_r8");
    if (op_i == OP_AND || op_i == OP_OR || op_i == OP_SLT)
      p_logic_noovf_r9: assert (!ovf_o) else $error("p_logic_noovf_r9");
    if (op_i == 3'b011 || op_i == 3'b100 || op_i == 3'b101)
      p_unused_r10: assert (res_o == '0 && !ovf_o && zero_o) else $error("p_unused_r10");
  end
endmodule

// File: tb/bitslice_alu_tb.sv
module bitslice_alu_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] a, b, res;
  logic [2:0]  op;
  logic        zero, ovf;

  bitslice_alu u_dut (.a_i(a), .b_i(b), .op_i(op), .res_o(res), .zero_o(zero), .ovf_o(ovf));

  typedef struct {
    logic [2:0]  op;
    logic [31:0] a, b, res;
    logic        zero, ovf;
  } item_t;

  item_t sb[$];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic item_t model(logic [2:0] o, logic [31:0] x, logic [31:0] y);
    item_t it;
    logic [31:0] s, d;
    s = x + y;
    d = x - y;
    it.op = o; it.a = x; it.b = y; it.ovf = 1'b0;
    case (o)
      3'b000: it.res = x & y;
      3'b001: it.res = x | y;
      3'b010: begin it.res = s; it.ovf = (x[31] == y[31]) && (s[31] != x[31]); end
      3'b110: begin it.res = d; it.ovf = (x[31] != y[31]) && (d[31] != x[31]); end
      3'b111: it.res = {31'd0, $signed(x) < $signed(y)};
      default: it.res = 32'd0;
    endcase
    it.zero = (it.res == 32'd0);
    return it;
  endfunction

  function automatic string res_tag(logic [2:0] o);
    case (o)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b110: return "R4";
      3'b111: return "R5";
      default: return "R10";
    endcase
  endfunction

  function automatic string ovf_tag(logic [2:0] o);
    case (o)
      3'b010: return "R7";
      3'b110: return "R8";
      3'b000, 3'b001, 3'b111: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic drive(logic [2:0] o, logic [31:0] x, logic [31:0] y);
    @(negedge clk);
    a = x; b = y; op = o;
    sb.push_back(model(o, x, y));
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, item_t it);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", tag, it.op, it.a, it.b, act, exp);
    end
  endtask

  // monitor: one item in flight, driven at negedge, sampled at next posedge
  always @(posedge clk) begin
    if (rst_n && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      chk(res_tag(it.op), res, it.res, it);
      chk("R6", {31'd0, zero}, {31'd0, it.zero}, it);
      chk(ovf_tag(it.op), {31'd0, ovf}, {31'd0, it.ovf}, it);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  logic [31:0] corner [5] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000};

  initial begin
    a = 0; b = 0; op = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle state: zero operands, AND gives zero result (R1, R6)
    drive(3'b000, 32'h0, 32'h0);
    // R5: most negative minus one overflows, still less
    drive(3'b111, 32'h8000_0000, 32'h1);
    drive(3'b111, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    // R8 / R7 boundaries
    drive(3'b110, 32'h8000_0000, 32'h1);
    drive(3'b010, 32'h7FFF_FFFF, 32'h1);
    drive(3'b110, 32'h1234_5678, 32'h1234_5678);
    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          drive(3'(o), corner[i], corner[j]);
    for (int k = 0; k < 300; k++)
      for (int o = 0; o < 8; o++)
        drive(3'(o), $urandom, $urandom);
    for (int k = 0; k < 100; k++) begin
      logic [31:0] v;
      v = $urandom;
      drive(3'b110, v, v);
      drive(3'b111, v, v);
    end
    while (sb.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule